// File: doc/BRIEF.md
# SIMT Divergence Reconvergence Stack

This block tracks control divergence for one warp of a SIMT core. It holds the warp's current thread mask and a stack of reconvergence entries. Split and join instructions, decoded elsewhere, drive the stack. A split supplies one predicate bit per thread and the address of the split instruction. A join pops one entry and then either sends fetch to the deferred path or restores the mask that was active before the divergence.

The thread mask is an output so that lanes whose bit is clear can be kept from writing registers and from touching memory. A separate load port sets the mask directly, as a thread-mask-change instruction does. A redirect pulse with a target address tells fetch where the deferred path begins. Full, empty and a sticky error flag report the state of the stack. Every update takes effect at the clock edge that samples the request.

Top module: `simt_reconv_stack`

## Requirements
- R1: After reset `thread_mask` has only bit 0 set, `stack_empty`=1, `stack_full`=0, `stack_err`=0 and `redirect_valid`=0.
- R2: A split where (mask AND pred) is zero or (mask AND NOT pred) is zero is a no-op: mask, stack and flags keep their values. This covers the cases of a single active thread and of a predicate on which all active threads agree.
- R3: A divergent split first pushes a reconvergence entry (flag=1) holding the old mask. It then pushes a deferred entry (flag=0) holding split_pc+4 and (mask AND NOT pred). Finally the mask becomes (mask AND pred).
- R4: A join that pops a deferred entry loads that entry's mask. In the next cycle it shows `redirect_valid`=1 for one cycle, with `redirect_pc` set to the entry's address.
- R5: A join that pops a reconvergence entry restores that entry's mask and gives no redirect.
- R6: A divergent split with fewer than two free entries, or a join on an empty stack, sets `stack_err` and leaves the mask and the stack unchanged. `stack_err` stays set until reset. A non-divergent split never raises it.
- R7: `mask_load_valid` writes `mask_load_value` into the thread mask and leaves the stack untouched.
- R8: When requests arrive in the same cycle, split wins over join and join wins over mask load. The losing requests are ignored.
- R9: The deferred address split_pc+4 wraps modulo 2^PC_W.
- R10: `stack_empty` is 1 exactly when no entries are held. `stack_full` is 1 exactly when DEPTH entries are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| split_valid | input | 1 | Split instruction this cycle |
| split_pred | input | NUM_THREADS | Per-thread predicate of the split |
| split_pc | input | PC_W | Address of the split instruction |
| join_valid | input | 1 | Join instruction this cycle |
| mask_load_valid | input | 1 | Direct thread-mask write |
| mask_load_value | input | NUM_THREADS | Value for the direct mask write |
| thread_mask | output | NUM_THREADS | Active-lane mask, gates per-lane side effects |
| redirect_valid | output | 1 | One-cycle fetch redirect |
| redirect_pc | output | PC_W | Redirect target |
| stack_full | output | 1 | DEPTH entries held |
| stack_empty | output | 1 | No entries held |
| stack_err | output | 1 | Sticky overflow or underflow flag |

## Verification
The hardest state to reach is overflow. Each divergence halves the active set, so four lanes run out of divergent splits long before eight entries are used. The stimulus reloads a full mask between splits with the load port, which fills the stack completely. It then pops a single entry to leave exactly one free slot, the boundary case, and tries a divergent split there. Nested divergence, the wrap of the deferred address, and same-cycle conflicts between requests are also covered.

// File: rtl/dvg_pkg.sv
package dvg_pkg;
  localparam int unsigned PC_W     = 32;
  localparam int unsigned INSN_LEN = 4;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_SPLIT = 2'd1,
    OP_JOIN  = 2'd2,
    OP_LOAD  = 2'd3
  } dvg_op_e;
endpackage

// File: rtl/dvg_split_eval.sv
module dvg_split_eval #(
  parameter int unsigned NUM_THREADS = 4
) (
  input  logic [NUM_THREADS-1:0] cur_mask,
  input  logic [NUM_THREADS-1:0] pred,
  output logic [NUM_THREADS-1:0] true_mask,
  output logic [NUM_THREADS-1:0] false_mask,
  output logic                   diverge
);
  always_comb begin
    true_mask  = cur_mask & pred;
    false_mask = cur_mask & ~pred;
    diverge    = (|true_mask) && (|false_mask);
  end

  always_comb begin
    if (diverge) begin
      a_div_split_r2 : assert ($countones(cur_mask) > 1)
        else $error("diverge with fewer than two active lanes");
    end
  end
endmodule

// File: rtl/dvg_stack.sv
module dvg_stack #(
  parameter int unsigned NUM_THREADS = 4,
  parameter int unsigned DEPTH       = 2 * NUM_THREADS,
  parameter int unsigned PC_W        = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   push2,
  input  logic [NUM_THREADS-1:0] push_rcv_mask,
  input  logic [PC_W-1:0]        push_pc,
  input  logic [NUM_THREADS-1:0] push_def_mask,
  input  logic                   pop,
  output logic                   top_rcv,
  output logic [PC_W-1:0]        top_pc,
  output logic [NUM_THREADS-1:0] top_mask,
  output logic                   empty,
  output logic                   full,
  output logic                   room2
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [CW-1:0]          cnt_q, cnt_d;
  logic                   rcv_q  [DEPTH];
  logic [PC_W-1:0]        pc_q   [DEPTH];
  logic [NUM_THREADS-1:0] mask_q [DEPTH];

  always_comb begin
    cnt_d = cnt_q;
    if (push2)    cnt_d = cnt_q + CW'(2);
    else if (pop) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (push2 || pop)      cnt_q <= cnt_d;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic wr_lo, wr_hi;
    assign wr_lo = push2 && (cnt_q == CW'(g));
    assign wr_hi = push2 && ((cnt_q + CW'(1)) == CW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rcv_q[g]  <= 1'b0;
        pc_q[g]   <= '0;
        mask_q[g] <= '0;
      end else if (wr_lo) begin
        rcv_q[g]  <= 1'b1;
        pc_q[g]   <= '0;
        mask_q[g] <= push_rcv_mask;
      end else if (wr_hi) begin
        rcv_q[g]  <= 1'b0;
        pc_q[g]   <= push_pc;
        mask_q[g] <= push_def_mask;
      end
    end
  end

  always_comb begin
    top_rcv  = 1'b0;
    top_pc   = '0;
    top_mask = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if ((cnt_q - CW'(1)) == CW'(i)) begin
        top_rcv  = rcv_q[i];
        top_pc   = pc_q[i];
        top_mask = mask_q[i];
      end
    end
  end

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));
  assign room2 = (cnt_q <= CW'(DEPTH - 2));

  p_push_room_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    push2 |-> room2);
  p_pop_nonempty_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  p_cnt_bound_r10 : assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  p_push_cnt_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    push2 |=> cnt_q == $past(cnt_q) + CW'(2));
endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack
  import dvg_pkg::*;
#(
  parameter int unsigned NUM_THREADS = 4,
  parameter int unsigned DEPTH       = 2 * NUM_THREADS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   split_valid,
  input  logic [NUM_THREADS-1:0] split_pred,
  input  logic [PC_W-1:0]        split_pc,
  input  logic                   join_valid,
  input  logic                   mask_load_valid,
  input  logic [NUM_THREADS-1:0] mask_load_value,
  output logic [NUM_THREADS-1:0] thread_mask,
  output logic                   redirect_valid,
  output logic [PC_W-1:0]        redirect_pc,
  output logic                   stack_full,
  output logic                   stack_empty,
  output logic                   stack_err
);
  dvg_op_e op;
  logic [NUM_THREADS-1:0] mask_q, mask_d, t_mask, f_mask, top_mask;
  logic diverge, room2, top_rcv;
  logic [PC_W-1:0] top_pc, next_pc;
  logic split_acc, split_ovf, join_acc, join_unf;
  logic err_q, err_d, redir_q, redir_d;
  logic [PC_W-1:0] rpc_q;

  always_comb begin
    if (split_valid)          op = OP_SPLIT;
    else if (join_valid)      op = OP_JOIN;
    else if (mask_load_valid) op = OP_LOAD;
    else                      op = OP_IDLE;
  end

  dvg_split_eval #(.NUM_THREADS(NUM_THREADS)) u_eval (
    .cur_mask  (mask_q),
    .pred      (split_pred),
    .true_mask (t_mask),
    .false_mask(f_mask),
    .diverge   (diverge)
  );

  assign next_pc = split_pc + PC_W'(INSN_LEN);

  always_comb begin
    split_acc = (op == OP_SPLIT) && diverge && room2;
    split_ovf = (op == OP_SPLIT) && diverge && !room2;
    join_acc  = (op == OP_JOIN) && !stack_empty;
    join_unf  = (op == OP_JOIN) && stack_empty;
  end

  dvg_stack #(.NUM_THREADS(NUM_THREADS), .DEPTH(DEPTH), .PC_W(PC_W)) u_stack (
    .clk          (clk),
    .rst_n        (rst_n),
    .push2        (split_acc),
    .push_rcv_mask(mask_q),
    .push_pc      (next_pc),
    .push_def_mask(f_mask),
    .pop          (join_acc),
    .top_rcv      (top_rcv),
    .top_pc       (top_pc),
    .top_mask     (top_mask),
    .empty        (stack_empty),
    .full         (stack_full),
    .room2        (room2)
  );

  always_comb begin
    mask_d = mask_q;
    if (split_acc)              mask_d = t_mask;
    else if (join_acc)          mask_d = top_mask;
    else if (op == OP_LOAD)     mask_d = mask_load_value;
    err_d   = err_q | split_ovf | join_unf;
    redir_d = join_acc && !top_rcv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= NUM_THREADS'(1);
      err_q   <= 1'b0;
      redir_q <= 1'b0;
      rpc_q   <= '0;
    end else begin
      mask_q  <= mask_d;
      err_q   <= err_d;
      redir_q <= redir_d;
      if (redir_d) rpc_q <= top_pc;
    end
  end

  assign thread_mask    = mask_q;
  assign stack_err      = err_q;
  assign redirect_valid = redir_q;
  assign redirect_pc    = rpc_q;

  p_err_sticky_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    stack_err |=> stack_err);
  p_nodiv_hold_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    (split_valid && !diverge) |=> $stable(thread_mask));
  p_split_subset_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    split_acc |=> ((thread_mask & ~$past(thread_mask)) == '0) && (thread_mask != '0));
  p_rcv_noredir_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    (join_acc && top_rcv) |=> !redirect_valid);
  p_redir_cause_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    !join_valid |=> !redirect_valid);
  p_flags_excl_r10 : assert property (@(posedge clk) disable iff (!rst_n)
    !(stack_full && stack_empty));
endmodule

// File: tb/simt_reconv_stack_tb.sv
`timescale 1ns/1ps
module simt_reconv_stack_tb;
  localparam int N = 4;
  localparam int VW = 2 + N + 32 + N + 1 + 32 + 1;
  localparam int NV = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic split_valid = 1'b0, join_valid = 1'b0, mask_load_valid = 1'b0;
  logic [N-1:0] split_pred = '0, mask_load_value = '0;
  logic [31:0] split_pc = '0;
  logic [N-1:0] thread_mask;
  logic redirect_valid, stack_full, stack_empty, stack_err;
  logic [31:0] redirect_pc;
  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  simt_reconv_stack #(.NUM_THREADS(N), .DEPTH(2*N)) u_dut (
    .clk(clk), .rst_n(rst_n), .split_valid(split_valid), .split_pred(split_pred),
    .split_pc(split_pc), .join_valid(join_valid), .mask_load_valid(mask_load_valid),
    .mask_load_value(mask_load_value), .thread_mask(thread_mask),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .stack_full(stack_full), .stack_empty(stack_empty), .stack_err(stack_err)
  );

  // op: 1 split, 2 join, 3 load (value field). Expected mask, redirect, target, empty.
  localparam logic [VW-1:0] VEC [NV] = '{
    {2'd3, 4'b1111, 32'h0,        4'b1111, 1'b0, 32'h0,   1'b1},
    {2'd1, 4'b0011, 32'h100,      4'b0011, 1'b0, 32'h0,   1'b0},
    {2'd1, 4'b0001, 32'h200,      4'b0001, 1'b0, 32'h0,   1'b0},
    {2'd1, 4'b1111, 32'h300,      4'b0001, 1'b0, 32'h0,   1'b0},
    {2'd2, 4'b0000, 32'h0,        4'b0010, 1'b1, 32'h204, 1'b0},
    {2'd2, 4'b0000, 32'h0,        4'b0011, 1'b0, 32'h0,   1'b0},
    {2'd1, 4'b0000, 32'h400,      4'b0011, 1'b0, 32'h0,   1'b0},
    {2'd2, 4'b0000, 32'h0,        4'b1100, 1'b1, 32'h104, 1'b0},
    {2'd2, 4'b0000, 32'h0,        4'b1111, 1'b0, 32'h0,   1'b1},
    {2'd1, 4'b1010, 32'hFFFFFFFC, 4'b1010, 1'b0, 32'h0,   1'b0},
    {2'd2, 4'b0000, 32'h0,        4'b0101, 1'b1, 32'h0,   1'b0},
    {2'd2, 4'b0000, 32'h0,        4'b1111, 1'b0, 32'h0,   1'b1}
  };

  function automatic string row_tag(input int i);
    case (i)
      0: return "R7 load";
      1, 2: return "R3 nested split";
      3: return "R2 single lane";
      4, 7: return "R4 deferred pop";
      5, 8, 11: return "R5 reconverge";
      6: return "R2 uniform pred";
      9: return "R9 wrap split";
      default: return "R9 wrap target R4";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input bit s, input bit j, input bit l,
                       input logic [N-1:0] v, input logic [31:0] pc);
    @(negedge clk);
    split_valid = s; join_valid = j; mask_load_valid = l;
    split_pred = v; mask_load_value = v; split_pc = pc;
    @(negedge clk);
    split_valid = 1'b0; join_valid = 1'b0; mask_load_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 mask", 32'(thread_mask), 32'h1);
    chk("R1 empty", 32'(stack_empty), 32'h1);
    chk("R1 full", 32'(stack_full), 32'h0);
    chk("R1 err", 32'(stack_err), 32'h0);
    chk("R1 redirect", 32'(redirect_valid), 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op; logic [N-1:0] v, em; logic [31:0] pc, epc; logic er, ee;
      {op, v, pc, em, er, epc, ee} = VEC[i];
      drive(op == 2'd1, op == 2'd2, op == 2'd3, v, pc);
      chk(row_tag(i), 32'(thread_mask), 32'(em));
      chk(row_tag(i), 32'(redirect_valid), 32'(er));
      if (er) chk(row_tag(i), redirect_pc, epc);
      chk({row_tag(i), " R10 empty"}, 32'(stack_empty), 32'(ee));
    end
    chk("R6 no err on legal ops", 32'(stack_err), 32'h0);

    // Fill the stack to DEPTH by reloading a full mask between splits.
    do_reset();
    for (int k = 1; k <= 4; k++) begin
      drive(0, 0, 1, 4'b1111, 32'h0);
      drive(1, 0, 0, 4'b0011, 32'(k * 16));
    end
    chk("R10 full at depth", 32'(stack_full), 32'h1);
    drive(0, 0, 1, 4'b1111, 32'h0);
    drive(1, 0, 0, 4'b1111, 32'h90);
    chk("R6 nondiv split on full", 32'(stack_err), 32'h0);
    chk("R2 nondiv split mask", 32'(thread_mask), 32'hF);
    drive(0, 1, 0, 4'b0000, 32'h0);
    chk("R4 top after fill", redirect_pc, 32'h44);
    chk("R4 top mask", 32'(thread_mask), 32'hC);
    chk("R10 full clears", 32'(stack_full), 32'h0);
    drive(0, 0, 1, 4'b0111, 32'h0);
    drive(1, 0, 0, 4'b0001, 32'h50);
    chk("R6 overflow err", 32'(stack_err), 32'h1);
    chk("R6 overflow mask kept", 32'(thread_mask), 32'h7);
    drive(0, 1, 0, 4'b0000, 32'h0);
    chk("R6 stack unchanged", 32'(thread_mask), 32'hF);
    chk("R6 stack unchanged redirect", 32'(redirect_valid), 32'h0);
    chk("R6 err sticky", 32'(stack_err), 32'h1);

    do_reset();
    chk("R1 err cleared", 32'(stack_err), 32'h0);
    drive(0, 1, 0, 4'b0000, 32'h0);
    chk("R6 underflow err", 32'(stack_err), 32'h1);
    chk("R6 underflow mask kept", 32'(thread_mask), 32'h1);
    chk("R6 underflow no redirect", 32'(redirect_valid), 32'h0);

    do_reset();
    drive(0, 0, 1, 4'b1111, 32'h0);
    drive(1, 1, 0, 4'b0011, 32'h60);
    chk("R8 split beats join mask", 32'(thread_mask), 32'h3);
    chk("R8 split beats join empty", 32'(stack_empty), 32'h0);
    chk("R8 split beats join redirect", 32'(redirect_valid), 32'h0);
    drive(0, 1, 1, 4'b1000, 32'h0);
    chk("R8 join beats load mask", 32'(thread_mask), 32'hC);
    chk("R8 join beats load target", redirect_pc, 32'h64);
    chk("R8 no error", 32'(stack_err), 32'h0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule